// File: doc/BRIEF.md
# Serial Two-Word Combination Lock

This block is a Moore state machine that grants entry once a user keys in a two-word code. Each word is a small switch value. The user sets the switches and presses a key that gives a one-cycle strobe, then does the same for the second word. After the second strobe the block raises exactly one result line. It raises `door_open` when both words matched the fixed combination. It raises `code_error` when either word was wrong. The result stays up until a synchronous reset clears it.

A wrong first word is recorded but gives no sign at the outputs. The user learns the outcome only after the second word, so a guess of one word shows nothing about the code. Both outputs are decoded from the state register alone. They therefore change only at a clock edge and carry no glitches from the inputs. The combination and the word width are parameters. The default code is `01` followed by `11`.

Top module: `serial_code_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine returns to its idle state, which drives `door_open` and `code_error` low after that edge. Reset overrides a `key_enter` strobe in the same cycle, and it may be applied at any point, including partway through a sequence or after a result.
- R2: In a cycle where `key_enter` is low, the state is held, so the outputs do not change, whatever value `key_sw` carries.
- R3: The first `key_enter` strobe after reset takes `key_sw` as the first word and compares it with `CODE_FIRST`, which defaults to 2'b01.
- R4: If the first word equals `CODE_FIRST` and the second word equals `CODE_SECOND` (default 2'b11), `door_open` goes high in the cycle after the second strobe and `code_error` stays low.
- R5: If the first word is wrong, both outputs stay low after the first strobe. After the second strobe `code_error` goes high, whatever the second word is.
- R6: If the first word is right and the second word differs from `CODE_SECOND`, `code_error` goes high in the cycle after the second strobe and `door_open` stays low.
- R7: Once either result is showing, further strobes and switch values have no effect. The result is held until reset.
- R8: `door_open` and `code_error` are never high together, and neither output changes except in the cycle after a strobe or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| key_enter | input | 1 | Strobe, one cycle wide, that accepts the current switch word |
| key_sw | input | WORD_W | Switch value for the word being entered |
| door_open | output | 1 | High while the correct code has been accepted |
| code_error | output | 1 | High once a complete but wrong code has been entered |

## Verification
The assertions assume that the reset line is asserted from time zero and that `key_enter` is a clean pulse sampled once per edge. They do not assume that a strobe is only one cycle wide. The bench holds `rst` high from the first instant and changes every input on the falling edge, so each input is stable across the sampling edge. The bench raises `key_enter` for a single cycle per word, as a debounced button would, and varies `key_sw` freely between strobes.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    LK_IDLE    = 3'b000,
    LK_GOOD1   = 3'b001,
    LK_GRANTED = 3'b011,
    LK_WRONG1  = 3'b100,
    LK_DENIED  = 3'b101
  } lock_state_t;

  // Next-state rule; unused codes fall back to idle.
  function automatic lock_state_t lock_next(input lock_state_t cur,
                                            input logic strobe,
                                            input logic hit_first,
                                            input logic hit_second);
    lock_state_t nxt;
    nxt = cur;
    case (cur)
      LK_IDLE:    if (strobe) nxt = hit_first ? LK_GOOD1 : LK_WRONG1;
      LK_GOOD1:   if (strobe) nxt = hit_second ? LK_GRANTED : LK_DENIED;
      LK_WRONG1:  if (strobe) nxt = LK_DENIED;
      LK_GRANTED: nxt = LK_GRANTED;
      LK_DENIED:  nxt = LK_DENIED;
      default:    nxt = LK_IDLE;
    endcase
    return nxt;
  endfunction

  function automatic logic lock_is_open(input lock_state_t cur);
    return cur == LK_GRANTED;
  endfunction

  function automatic logic lock_is_error(input lock_state_t cur);
    return cur == LK_DENIED;
  endfunction

endpackage

// File: rtl/code_word_match.sv
module code_word_match #(
  parameter int WORD_W = 2,
  parameter logic [WORD_W-1:0] CODE_FIRST  = 2'b01,
  parameter logic [WORD_W-1:0] CODE_SECOND = 2'b11
) (
  input  logic [WORD_W-1:0] sw_i,
  output logic              hit_first_o,
  output logic              hit_second_o
);
  assign hit_first_o  = (sw_i == CODE_FIRST);
  assign hit_second_o = (sw_i == CODE_SECOND);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import code_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        strobe_i,
  input  logic        hit_first_i,
  input  logic        hit_second_i,
  output lock_state_t state_o
);
  lock_state_t state_q;
  lock_state_t state_d;

  always_comb state_d = lock_next(state_q, strobe_i, hit_first_i, hit_second_i);

  always_ff @(posedge clk) begin
    if (rst) state_q <= LK_IDLE;
    else     state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/lock_decode.sv
module lock_decode
  import code_lock_pkg::*;
(
  input  lock_state_t state_i,
  output logic        open_o,
  output logic        error_o
);
  assign open_o  = lock_is_open(state_i);
  assign error_o = lock_is_error(state_i);
endmodule

// File: rtl/serial_code_lock.sv
module serial_code_lock
  import code_lock_pkg::*;
#(
  parameter int WORD_W = 2,
  parameter logic [WORD_W-1:0] CODE_FIRST  = 2'b01,
  parameter logic [WORD_W-1:0] CODE_SECOND = 2'b11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_enter,
  input  logic [WORD_W-1:0] key_sw,
  output logic              door_open,
  output logic              code_error
);
  logic        hit_first;
  logic        hit_second;
  lock_state_t lock_state;

  code_word_match #(
    .WORD_W(WORD_W),
    .CODE_FIRST(CODE_FIRST),
    .CODE_SECOND(CODE_SECOND)
  ) u_match (
    .sw_i(key_sw),
    .hit_first_o(hit_first),
    .hit_second_o(hit_second)
  );

  lock_fsm u_fsm (
    .clk(clk),
    .rst(rst),
    .strobe_i(key_enter),
    .hit_first_i(hit_first),
    .hit_second_i(hit_second),
    .state_o(lock_state)
  );

  lock_decode u_dec (
    .state_i(lock_state),
    .open_o(door_open),
    .error_o(code_error)
  );
endmodule

// File: rtl/lock_checker.sv
module lock_checker (
  input logic clk,
  input logic rst,
  input logic key_enter,
  input logic door_open,
  input logic code_error
);
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!door_open && !code_error)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(key_enter) && !$past(rst)) |-> ($stable(door_open) && $stable(code_error))); // R2

  AST_OPEN_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(door_open) |-> $past(key_enter)); // R4

  AST_ERROR_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(code_error) |-> $past(key_enter)); // R5

  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(door_open) && !$past(rst)) |-> door_open); // R7

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(code_error) && !$past(rst)) |-> code_error); // R7

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(door_open && code_error)); // R8
endmodule

bind serial_code_lock lock_checker u_chk (
  .clk(clk),
  .rst(rst),
  .key_enter(key_enter),
  .door_open(door_open),
  .code_error(code_error)
);

// File: tb/sim_serial_code_lock.sv
`timescale 1ns/1ps
module sim_serial_code_lock;
  localparam logic [1:0] C1 = 2'b01;
  localparam logic [1:0] C2 = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_enter = 1'b0;
  logic [1:0] key_sw = 2'b00;
  logic       door_open;
  logic       code_error;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R1";

  // reference model: words accepted and whether any was wrong
  int words = 0;
  bit wrong = 0;

  always #2.5 clk = ~clk;

  serial_code_lock u0 (
    .clk(clk), .rst(rst), .key_enter(key_enter), .key_sw(key_sw),
    .door_open(door_open), .code_error(code_error)
  );

  always @(posedge clk) begin
    if (rst) begin
      words = 0;
      wrong = 0;
    end else if (key_enter && words < 2) begin
      if (key_sw != ((words == 0) ? C1 : C2)) wrong = 1;
      words = words + 1;
    end
  end

  // every-clock comparison, on the falling edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (door_open !== (words == 2 && !wrong) || code_error !== (words == 2 && wrong)) begin
        errors++;
        $display("FAIL %s model: open=%b err=%b expected open=%b err=%b", phase,
                 door_open, code_error, (words == 2 && !wrong), (words == 2 && wrong));
      end
    end
  end

  task automatic check(input string req, input logic eo, input logic ee);
    checks++;
    if (door_open !== eo || code_error !== ee) begin
      errors++;
      $display("FAIL %s: open=%b err=%b expected open=%b err=%b", req,
               door_open, code_error, eo, ee);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      key_sw = key_sw + 2'b01;
      @(negedge clk);
    end
  endtask

  task automatic press(input logic [1:0] w);
    key_sw = w;
    key_enter = 1'b1;
    @(negedge clk);
    key_enter = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    check("R1", 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    phase = "R4";
    press(C1); idle(3);
    check("R2", 1'b0, 1'b0);
    press(C2);
    check("R4", 1'b1, 1'b0);

    phase = "R7";
    press(2'b00); press(C1); idle(2);
    check("R7", 1'b1, 1'b0);

    phase = "R1";
    rst = 1'b1; key_enter = 1'b1; key_sw = C1;
    @(negedge clk);
    rst = 1'b0; key_enter = 1'b0;
    check("R1", 1'b0, 1'b0);

    phase = "R5";
    press(2'b00);
    check("R5", 1'b0, 1'b0);
    idle(2);
    press(C2);
    check("R5", 1'b0, 1'b1);
    press(C1); press(C2);
    check("R7", 1'b0, 1'b1);

    do_reset();
    phase = "R3";
    press(C2); press(C2);
    check("R3", 1'b0, 1'b1);

    do_reset();
    phase = "R6";
    press(C1); press(2'b10);
    check("R6", 1'b0, 1'b1);

    do_reset();
    phase = "R1";
    press(C1); do_reset();
    press(C2); press(C2);
    check("R1", 1'b0, 1'b1);

    do_reset();
    phase = "R2";
    idle(5);
    check("R2", 1'b0, 1'b0);
    press(C1); press(C2);
    check("R2", 1'b1, 1'b0);

    phase = "R8";
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        do_reset();
        press(a[1:0]); idle(1); press(b[1:0]);
        check("R8", (a[1:0] == C1 && b[1:0] == C2), !(a[1:0] == C1 && b[1:0] == C2));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule